// File: doc/BRIEF.md
# TDM Audio Frame Timing Generator

This block produces the timing skeleton of a time-division-multiplexed audio serial port. It divides a master clock down to a bit clock. Over that bit clock it counts out frames and drives a frame sync. For every bit period it also reports which slot is active, the bit position inside that slot, and whether the bit carries sample data or padding. A serializer placed next to the block uses these strobes to shift samples in and out. The block does not move any sample data itself.

One counting engine covers four frame formats, coded on `cfg_fmt`:

| Code | Format |
|------|--------|
| 0 | I2S |
| 1 | left-justified |
| 2 | DSP-A |
| 3 | DSP-B |

The formats differ in three ways:

- the width of the frame sync pulse;
- whether data starts one bit after the sync edge;
- the idle level of the sync line.

In the two-slot formats (codes 0 and 1), padding is shared out to the end of each half-frame slot. In the DSP formats (codes 2 and 3), all padding collects after the last slot. Software-facing logic presents a configuration and pulses `cfg_load`. The block checks the configuration and adopts it only when the port is stopped.

Top module: `tdm_frame_gen`

## Requirements
- R1: While running, `bclk` has a period of `div+1` master clocks. Each bit period opens with `(div+1)/2` master clocks (rounded down) at the level `cfg_bclk_inv`, and the rest of the period is at the opposite level. While stopped, `bclk` rests at `cfg_bclk_inv`.
- R2: A frame lasts exactly `frame` bit periods, and the sync becomes active in the first bit period of every frame.
- R3: With codes 0 and 2, bit 0 of slot 0 falls one bit period after the sync becomes active. With codes 1 and 3, it coincides with the sync becoming active.
- R4: The sync stays active for `frame/2` bit periods with codes 0 and 1, and for one bit period with codes 2 and 3.
- R5: The active sync level is low for code 0 and high for codes 1 to 3. Setting `cfg_fs_inv` swaps the active and idle levels.
- R6: Codes 0 and 1 divide the frame into two slots of `frame/2` bits each. Within a slot, the first `valid` bits are data and the remaining bits are padding.
- R7: Codes 2 and 3 place `slots` slots of `valid` data bits back to back. The rest of the frame is padding. During that padding, `slot_idx` stays at the last slot and `bit_idx` continues counting upward.
- R8: A load is rejected, raising `cfg_err` and keeping the old settings, if any of the following holds:
  - the divider is zero;
  - `slots` is zero or `valid` is zero;
  - `frame` is smaller than `slots*valid`;
  - a slot would be wider than 38 bits;
  - for codes 0 and 1: `slots` is not 2, `frame` is odd, or the padding per slot exceeds 15.
- R9: A load presented while `enable` is high is refused. It sets `cfg_err` and leaves the running timing unchanged. An accepted load clears `cfg_err`.
- R10: A rising `enable` restarts the frame at bit 0 with the sync active. While `enable` is low, the data and pad strobes are low, the indices are zero and the sync is idle.
- R11: While running, exactly one of `data_valid` and `pad_bit` is high in each bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | run the port |
| cfg_load | input | 1 | present the configuration inputs for adoption |
| cfg_div | input | DIV_W | bit clock divider minus one |
| cfg_slots | input | SLOT_W | slot count |
| cfg_valid | input | BITS_W | data bits per slot |
| cfg_frame | input | FRAME_W | bit periods per frame |
| cfg_fmt | input | 2 | frame format code (0 to 3) |
| cfg_fs_inv | input | 1 | swap sync polarity |
| cfg_bclk_inv | input | 1 | swap bit clock polarity |
| bclk | output | 1 | bit clock |
| fsync | output | 1 | frame sync |
| slot_idx | output | SLOT_W | current slot |
| bit_idx | output | FRAME_W | bit position within the slot |
| data_valid | output | 1 | current bit carries data |
| pad_bit | output | 1 | current bit is padding |
| cfg_err | output | 1 | last load was rejected |

## Verification
`cfg_err` settles one master clock after the edge that samples `cfg_load`. All frame outputs show bit period 0 one master clock after the edge that samples `enable` rising. After that, the strobes and indices change only on bit-period boundaries, every `div+1` clocks, while `bclk` changes within each period. The bench drives inputs on falling edges and compares every output at every falling edge. It builds its reference from the elapsed clock count alone, using division and remainder. This makes each check land one register stage after the edge that caused it. The bench sweeps all formats, both sync polarities, both clock polarities and several geometries, including padded and unpadded frames and the 15-bit and 38-bit limits.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } fmt_e;

  localparam int MAX_SLOT_BITS = 38;
  localparam int MAX_HALF_PAD  = 15;

  // two half-frame slots with per-slot padding
  function automatic logic two_slot(fmt_e f);
    return (f == FMT_I2S) || (f == FMT_LJ);
  endfunction

  // data starts one bit after the sync edge
  function automatic logic late_start(fmt_e f);
    return (f == FMT_I2S) || (f == FMT_DSPA);
  endfunction
endpackage

// File: rtl/tdm_cfg_unit.sv
module tdm_cfg_unit
  import tdm_frame_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SLOT_W  = 4,
  parameter int BITS_W  = 6,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               cfg_load,
  input  logic [DIV_W-1:0]   in_div,
  input  logic [SLOT_W-1:0]  in_slots,
  input  logic [BITS_W-1:0]  in_valid,
  input  logic [FRAME_W-1:0] in_frame,
  input  fmt_e               in_fmt,
  input  logic               in_fs_inv,
  input  logic               in_bclk_inv,
  output logic [DIV_W-1:0]   act_div,
  output logic [SLOT_W-1:0]  act_slots,
  output logic [BITS_W-1:0]  act_valid,
  output logic [FRAME_W-1:0] act_frame,
  output fmt_e               act_fmt,
  output logic               act_fs_inv,
  output logic               act_bclk_inv,
  output logic [FRAME_W-1:0] act_slot_bits,
  output logic [FRAME_W-1:0] act_last_bit,
  output logic               cfg_err
);
  localparam int PW = FRAME_W + SLOT_W + BITS_W + 1;

  logic [PW-1:0] frame_w, need_w, half_w, half_pad, sw_w, lastb_w;
  logic          bad;

  always_comb begin
    frame_w  = PW'(in_frame);
    need_w   = PW'(in_slots) * PW'(in_valid);
    half_w   = frame_w >> 1;
    half_pad = half_w - PW'(in_valid);
    sw_w     = two_slot(in_fmt) ? half_w : PW'(in_valid);
    lastb_w  = frame_w - PW'(1) - (PW'(in_slots) - PW'(1)) * sw_w;
    bad = (in_div == '0) || (in_slots == '0) || (in_valid == '0) ||
          (frame_w < need_w) || (sw_w > PW'(MAX_SLOT_BITS));
    if (two_slot(in_fmt))
      bad = bad || (in_slots != SLOT_W'(2)) || in_frame[0] ||
            (half_pad > PW'(MAX_HALF_PAD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div       <= DIV_W'(1);
      act_slots     <= SLOT_W'(2);
      act_valid     <= BITS_W'(16);
      act_frame     <= FRAME_W'(32);
      act_fmt       <= FMT_I2S;
      act_fs_inv    <= 1'b0;
      act_bclk_inv  <= 1'b0;
      act_slot_bits <= FRAME_W'(16);
      act_last_bit  <= FRAME_W'(15);
      cfg_err       <= 1'b0;
    end else if (cfg_load) begin
      if (enable || bad) begin
        cfg_err <= 1'b1;
      end else begin
        cfg_err       <= 1'b0;
        act_div       <= in_div;
        act_slots     <= in_slots;
        act_valid     <= in_valid;
        act_frame     <= in_frame;
        act_fmt       <= in_fmt;
        act_fs_inv    <= in_fs_inv;
        act_bclk_inv  <= in_bclk_inv;
        act_slot_bits <= FRAME_W'(sw_w);
        act_last_bit  <= FRAME_W'(lastb_w);
      end
    end
  end
endmodule

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic             bclk_inv,
  output logic             start,
  output logic             tick,
  output logic             bclk
);
  logic             run_q;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W:0]   half;

  assign start = enable && !run_q;
  assign tick  = enable && run_q && (cnt_q == div);
  assign half  = ({1'b0, div} + 1'b1) >> 1;
  assign cnt_n = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else begin
      run_q <= enable;
      if (start) begin
        cnt_q <= '0;
        bclk  <= bclk_inv;
      end else if (enable && run_q) begin
        cnt_q <= cnt_n;
        bclk  <= ({1'b0, cnt_n} >= half) ^ bclk_inv;
      end else begin
        cnt_q <= '0;
        bclk  <= bclk_inv;
      end
    end
  end
endmodule

// File: rtl/tdm_frame_cnt.sv
module tdm_frame_cnt
  import tdm_frame_pkg::*;
#(
  parameter int SLOT_W  = 4,
  parameter int BITS_W  = 6,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               start,
  input  logic               tick,
  input  fmt_e               fmt,
  input  logic               fs_inv,
  input  logic [SLOT_W-1:0]  slots,
  input  logic [BITS_W-1:0]  valid,
  input  logic [FRAME_W-1:0] frame,
  input  logic [FRAME_W-1:0] slot_bits,
  input  logic [FRAME_W-1:0] last_bit,
  output logic               fsync,
  output logic [SLOT_W-1:0]  slot_idx,
  output logic [FRAME_W-1:0] bit_idx,
  output logic               data_valid,
  output logic               pad_bit
);
  logic [FRAME_W-1:0] pos_q, pos_n, dpos_q, dpos_n, bit_n, fs_w;
  logic [SLOT_W-1:0]  slot_n, last_slot;
  logic               pol_hi, is_data;

  assign last_slot = slots - SLOT_W'(1);
  assign fs_w      = two_slot(fmt) ? (frame >> 1) : FRAME_W'(1);
  assign pol_hi    = (fmt != FMT_I2S) ^ fs_inv;

  always_comb begin
    pos_n  = pos_q;
    dpos_n = dpos_q;
    slot_n = slot_idx;
    bit_n  = bit_idx;
    if (start) begin
      pos_n = '0;
      if (late_start(fmt)) begin
        dpos_n = frame - FRAME_W'(1);
        slot_n = last_slot;
        bit_n  = last_bit;
      end else begin
        dpos_n = '0;
        slot_n = '0;
        bit_n  = '0;
      end
    end else if (tick) begin
      pos_n = (pos_q == frame - FRAME_W'(1)) ? '0 : pos_q + FRAME_W'(1);
      if (dpos_q == frame - FRAME_W'(1)) begin
        dpos_n = '0;
        slot_n = '0;
        bit_n  = '0;
      end else begin
        dpos_n = dpos_q + FRAME_W'(1);
        if ((bit_idx == slot_bits - FRAME_W'(1)) && (slot_idx != last_slot)) begin
          slot_n = slot_idx + SLOT_W'(1);
          bit_n  = '0;
        end else begin
          bit_n = bit_idx + FRAME_W'(1);
        end
      end
    end
    is_data = bit_n < FRAME_W'(valid);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pos_q      <= '0;
      dpos_q     <= '0;
      slot_idx   <= '0;
      bit_idx    <= '0;
      data_valid <= 1'b0;
      pad_bit    <= 1'b0;
      fsync      <= rst ? 1'b1 : !pol_hi;
    end else if (start || tick) begin
      pos_q      <= pos_n;
      dpos_q     <= dpos_n;
      slot_idx   <= slot_n;
      bit_idx    <= bit_n;
      data_valid <= is_data;
      pad_bit    <= !is_data;
      fsync      <= (pos_n < fs_w) ? pol_hi : !pol_hi;
    end
  end
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdm_frame_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SLOT_W  = 4,
  parameter int BITS_W  = 6,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               cfg_load,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [SLOT_W-1:0]  cfg_slots,
  input  logic [BITS_W-1:0]  cfg_valid,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic [1:0]         cfg_fmt,
  input  logic               cfg_fs_inv,
  input  logic               cfg_bclk_inv,
  output logic               bclk,
  output logic               fsync,
  output logic [SLOT_W-1:0]  slot_idx,
  output logic [FRAME_W-1:0] bit_idx,
  output logic               data_valid,
  output logic               pad_bit,
  output logic               cfg_err
);
  logic [DIV_W-1:0]   act_div;
  logic [SLOT_W-1:0]  act_slots;
  logic [BITS_W-1:0]  act_valid;
  logic [FRAME_W-1:0] act_frame, act_slot_bits, act_last_bit;
  fmt_e               act_fmt;
  logic               act_fs_inv, act_bclk_inv;
  logic               start, tick;

  tdm_cfg_unit #(.DIV_W(DIV_W), .SLOT_W(SLOT_W), .BITS_W(BITS_W), .FRAME_W(FRAME_W)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable), .cfg_load(cfg_load),
    .in_div(cfg_div), .in_slots(cfg_slots), .in_valid(cfg_valid), .in_frame(cfg_frame),
    .in_fmt(fmt_e'(cfg_fmt)), .in_fs_inv(cfg_fs_inv), .in_bclk_inv(cfg_bclk_inv),
    .act_div(act_div), .act_slots(act_slots), .act_valid(act_valid), .act_frame(act_frame),
    .act_fmt(act_fmt), .act_fs_inv(act_fs_inv), .act_bclk_inv(act_bclk_inv),
    .act_slot_bits(act_slot_bits), .act_last_bit(act_last_bit), .cfg_err(cfg_err)
  );

  tdm_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .enable(enable), .div(act_div), .bclk_inv(act_bclk_inv),
    .start(start), .tick(tick), .bclk(bclk)
  );

  tdm_frame_cnt #(.SLOT_W(SLOT_W), .BITS_W(BITS_W), .FRAME_W(FRAME_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .tick(tick),
    .fmt(act_fmt), .fs_inv(act_fs_inv), .slots(act_slots), .valid(act_valid),
    .frame(act_frame), .slot_bits(act_slot_bits), .last_bit(act_last_bit),
    .fsync(fsync), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .data_valid(data_valid), .pad_bit(pad_bit)
  );
endmodule

// File: rtl/tdm_frame_gen_chk.sv
module tdm_frame_gen_chk #(
  parameter int SLOT_W  = 4,
  parameter int FRAME_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic               cfg_load,
  input logic               cfg_err,
  input logic               data_valid,
  input logic               pad_bit,
  input logic [SLOT_W-1:0]  slot_idx,
  input logic [FRAME_W-1:0] bit_idx,
  input logic               start,
  input logic               tick,
  input logic [SLOT_W-1:0]  act_slots
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_valid, pad_bit}));

  assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!data_valid && !pad_bit && slot_idx == '0 && bit_idx == '0));

  assert_refuse_running_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && enable) |=> cfg_err);

  assert_slot_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    slot_idx < act_slots);

  assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(start) && !$past(tick)) |-> ($stable(bit_idx) && $stable(slot_idx)));
endmodule

bind tdm_frame_gen tdm_frame_gen_chk #(.SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cfg_load(cfg_load), .cfg_err(cfg_err),
  .data_valid(data_valid), .pad_bit(pad_bit), .slot_idx(slot_idx), .bit_idx(bit_idx),
  .start(start), .tick(tick), .act_slots(act_slots)
);

// File: tb/tdm_frame_gen_tb.sv
module tdm_frame_gen_tb;
  localparam int DIV_W = 8, SLOT_W = 4, BITS_W = 6, FRAME_W = 10;

  logic clk = 1'b0;
  logic rst, enable, cfg_load, cfg_fs_inv, cfg_bclk_inv;
  logic [DIV_W-1:0]   cfg_div;
  logic [SLOT_W-1:0]  cfg_slots;
  logic [BITS_W-1:0]  cfg_valid;
  logic [FRAME_W-1:0] cfg_frame;
  logic [1:0]         cfg_fmt;
  logic bclk, fsync, data_valid, pad_bit, cfg_err;
  logic [SLOT_W-1:0]  slot_idx;
  logic [FRAME_W-1:0] bit_idx;

  int checks = 0, fails = 0;
  int m_div, m_s, m_v, m_f, m_fmt, m_fsi, m_bi;

  always #10 clk = ~clk;

  tdm_frame_gen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W), .BITS_W(BITS_W), .FRAME_W(FRAME_W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_load(cfg_load),
    .cfg_div(cfg_div), .cfg_slots(cfg_slots), .cfg_valid(cfg_valid), .cfg_frame(cfg_frame),
    .cfg_fmt(cfg_fmt), .cfg_fs_inv(cfg_fs_inv), .cfg_bclk_inv(cfg_bclk_inv),
    .bclk(bclk), .fsync(fsync), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .data_valid(data_valid), .pad_bit(pad_bit), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int dv, input int s, input int v, input int f, input int fmt,
                      input int fsi, input int bi, input int exp_err);
    @(negedge clk);
    cfg_div = DIV_W'(dv); cfg_slots = SLOT_W'(s); cfg_valid = BITS_W'(v);
    cfg_frame = FRAME_W'(f); cfg_fmt = 2'(fmt); cfg_fs_inv = fsi[0]; cfg_bclk_inv = bi[0];
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(exp_err ? "R8" : "R9", "cfg_err", int'(cfg_err), exp_err);
    if (exp_err == 0) begin
      m_div = dv; m_s = s; m_v = v; m_f = f; m_fmt = fmt; m_fsi = fsi; m_bi = bi;
    end
  endtask

  task automatic check_idle();
    int polhi;
    polhi = ((m_fmt != 0) ? 1 : 0) ^ m_fsi;
    chk("R10", "idle data_valid", int'(data_valid), 0);
    chk("R10", "idle pad_bit", int'(pad_bit), 0);
    chk("R10", "idle slot_idx", int'(slot_idx), 0);
    chk("R10", "idle bit_idx", int'(bit_idx), 0);
    chk("R10", "idle fsync", int'(fsync), 1 - polhi);
    chk("R1", "idle bclk", int'(bclk), m_bi);
  endtask

  task automatic check_cycle(input int k);
    int bp, b, c, p, d, q, sw, e_slot, e_bit, e_dv, fsw, polhi, e_fs;
    bit two;
    bp = m_div + 1; b = k / bp; c = k % bp; p = b % m_f;
    d = (m_fmt == 0 || m_fmt == 2) ? 1 : 0;
    q = (p - d + m_f) % m_f;
    two = (m_fmt < 2);
    if (two) begin
      sw = m_f / 2; e_slot = q / sw; e_bit = q % sw;
    end else if (q < m_s * m_v) begin
      e_slot = q / m_v; e_bit = q % m_v;
    end else begin
      e_slot = m_s - 1; e_bit = q - (m_s - 1) * m_v;
    end
    e_dv  = (e_bit < m_v) ? 1 : 0;
    fsw   = two ? m_f / 2 : 1;
    polhi = ((m_fmt != 0) ? 1 : 0) ^ m_fsi;
    e_fs  = (p < fsw) ? polhi : 1 - polhi;
    chk("R1", "bclk", int'(bclk), ((c >= bp / 2) ? 1 : 0) ^ m_bi);
    if (k == 0)
      chk("R5", "fsync at start", int'(fsync), e_fs);
    else if (p == 0)
      chk("R2", "fsync at frame start", int'(fsync), e_fs);
    else
      chk("R4", "fsync", int'(fsync), e_fs);
    if (p == d) begin
      chk("R3", "slot at first data bit", int'(slot_idx), 0);
      chk("R3", "bit at first data bit", int'(bit_idx), 0);
    end else begin
      chk(two ? "R6" : "R7", "slot_idx", int'(slot_idx), e_slot);
      chk(two ? "R6" : "R7", "bit_idx", int'(bit_idx), e_bit);
    end
    chk("R11", "data_valid", int'(data_valid), e_dv);
    chk("R11", "pad_bit", int'(pad_bit), 1 - e_dv);
  endtask

  // runs from a rising enable; inject>0 presents a load at that cycle
  task automatic run(input int frames, input int inject);
    int total;
    total = frames * (m_div + 1) * m_f + 2;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      check_cycle(k);
      if (inject > 0 && k == inject) begin
        cfg_div = 8'd3; cfg_slots = 4'd1; cfg_valid = 6'd4; cfg_frame = 10'd6;
        cfg_fmt = 2'd3; cfg_fs_inv = ~cfg_fs_inv;
        cfg_load = 1'b1;
      end
      if (inject > 0 && k == inject + 1) begin
        cfg_load = 1'b0;
        chk("R9", "cfg_err after refused load", int'(cfg_err), 1);
      end
    end
    enable = 1'b0;
    @(negedge clk);
    check_idle();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R10 watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; cfg_load = 1'b0;
    cfg_div = '0; cfg_slots = '0; cfg_valid = '0; cfg_frame = '0;
    cfg_fmt = '0; cfg_fs_inv = 1'b0; cfg_bclk_inv = 1'b0;
    m_div = 1; m_s = 2; m_v = 16; m_f = 32; m_fmt = 0; m_fsi = 0; m_bi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "reset cfg_err", int'(cfg_err), 0);
    check_idle();
    run(1, 0);

    for (int fmt = 0; fmt < 4; fmt++)
      for (int fsi = 0; fsi < 2; fsi++)
        for (int g = 0; g < 2; g++) begin
          if (fmt < 2) begin
            if (g == 0) load(1, 2, 4, 8, fmt, fsi, fsi ^ fmt[0], 0);
            else        load(2, 2, 3, 10, fmt, fsi, 1 - (fsi ^ fmt[0]), 0);
          end else begin
            if (g == 0) load(1, 3, 3, 12, fmt, fsi, fsi, 0);
            else        load(4, 4, 2, 9, fmt, fsi, 1 - fsi, 0);
          end
          run(2, 0);
        end

    // boundary geometries
    load(3, 2, 5, 12, 0, 0, 0, 0);  run(2, 0);
    load(1, 2, 4, 38, 1, 0, 0, 0);  run(1, 0);   // 15 pad bits per slot
    load(1, 1, 38, 40, 2, 1, 0, 0); run(1, 0);   // 38-bit slot
    load(1, 2, 4, 8, 3, 0, 1, 0);

    // rejected loads: old settings must stay
    load(0, 2, 4, 8, 0, 0, 0, 1);   // divider zero
    load(1, 3, 4, 10, 2, 0, 0, 1);  // frame too short
    load(1, 2, 4, 9, 0, 0, 0, 1);   // odd frame in two-slot mode
    load(1, 2, 4, 40, 1, 0, 0, 1);  // 16 pad bits per slot
    load(1, 1, 39, 40, 3, 0, 0, 1); // slot wider than 38
    load(1, 3, 4, 24, 0, 0, 0, 1);  // three slots in two-slot mode
    load(1, 0, 4, 8, 2, 0, 0, 1);   // zero slots
    load(1, 2, 0, 8, 2, 0, 0, 1);   // zero valid bits
    run(2, 0);

    // load during a run is refused and timing continues unchanged
    load(2, 2, 3, 10, 0, 1, 0, 0);
    run(3, 7);
    load(1, 2, 4, 8, 1, 0, 0, 0);
    run(1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule